// File: doc/BRIEF.md
# Register-Programmed Block Copy Engine

The engine copies a block of bytes from one address range to another over a single memory master port. Software programs a source address, a destination address, a byte count and one configuration word for each side, then writes a start command. The configuration word of a side sets that side's beat width (8, 16 or 32 bits), its burst length and whether its address increments or stays fixed. The usual pairing puts a 16-bit flash buffer window on one side and 32-bit system memory on the other. The engine packs narrow beats into wide ones, or splits wide beats into narrow ones, in little-endian order.

The copy runs in chunks. Each chunk is as long as the longer of the two sides' bursts, and the last chunk is cut down to the bytes that remain. All read beats of a chunk are issued back to back into an internal staging buffer, and the write beats follow. Status shows busy, done and error. Done and error stay set until software clears each one with its own command bit, and a memory error response ends the copy at once.

Top module: `blkdma_top`

## Requirements
- R1: Registers sit at these byte offsets: source address 0x00, source config 0x04, destination address 0x08, destination config 0x0C, byte count 0x14, command 0x18, status 0x1C, direction 0x20. Address, count and direction read back as written, with the count truncated to LEN_W bits and the direction to bit 0. A config register reads back only bits 18:16, 8 and 1:0. Command reads as zero.
- R2: In a config word, bits 18:16 give the burst length (2, 3 and 4 give 4, 8 and 16 beats; every other code gives single beats). Bit 8 set holds the address fixed. Bits 1:0 give the beat width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; 3 is invalid).
- R3: Writing 1 to command bit 0 while idle starts a valid copy. Status bit 17 (busy) is set from the next cycle, and done and error are cleared. Memory requests are only made while busy.
- R4: When the last write beat is answered, busy clears and status bit 18 (done) sets. Done stays set until command bit 18 is written with 1.
- R5: Writing 1 to command bit 16 clears status bit 16 (error) and leaves done alone. Done is cleared separately.
- R6: A start with a zero byte count, with a count that is not a multiple of the wider side's beat size, or with a width code of 3 on either side sets error and done and makes no memory request.
- R7: Bytes land at the destination in source address order. When a 16-bit side meets a 32-bit side, the lower-addressed half-word goes in bits 15:0.
- R8: The chunk length is the smaller of the remaining count and the longer side's burst length in bytes. Every read beat of a chunk is issued before the first write beat of that chunk, and a copy uses count divided by source beat size read beats.
- R9: A side with the fixed-address bit set uses its base address for every beat. For a fixed destination, the last beat written wins.
- R10: A memory response flagged as an error ends the copy. Busy clears, error and done set, and no further requests are made.
- R11: A start command written while busy is ignored, and the running copy completes unchanged.
- R12: A request held back by a low ready keeps its address, direction and (for writes) data and strobes unchanged. The strobes of a write beat cover one, two or four lanes starting at address bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | 32 | Beat byte address |
| mem_req_wdata | output | 32 | Write data, byte lanes by address bits 1:0 |
| mem_req_strb | output | 4 | Write byte-lane strobes |
| mem_rsp_valid | input | 1 | Response, in request order, at least one cycle after acceptance |
| mem_rsp_rdata | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Response carries an error |

## Verification
The bench builds the engine with its defaults: LEN_W of 16 and MAX_BURST_LOG of 4. This gives a 64-byte staging buffer, so a 16-beat burst of 32-bit beats fits in one chunk. With these values, a 100-byte copy from 16-bit to 32-bit runs as one full 64-byte chunk followed by a shortened 36-byte chunk. Lane placement at offset 2, fixed-address sides, 8-bit to 32-bit packing and back-pressure on every third cycle are all exercised against a 256-byte memory model in the bench.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  localparam int ADDR_W    = 32;
  localparam int BUS_BYTES = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;

  typedef struct packed {
    logic [2:0] burst;
    logic       fixed;
    logic [1:0] width;
  } side_cfg_t;

  // log2 of burst beat count for a burst code
  function automatic int unsigned burst_log(logic [2:0] code, int unsigned cap);
    int unsigned r;
    case (code)
      3'd2:    r = 2;
      3'd3:    r = 3;
      3'd4:    r = 4;
      default: r = 0;
    endcase
    return (r > cap) ? cap : r;
  endfunction

  // log2 of the bytes one burst of this side spans
  function automatic int unsigned side_span(side_cfg_t c, int unsigned cap);
    return int'(c.width) + burst_log(c.burst, cap);
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(logic [ADDR_W-1:0] base, logic fixed,
                                                  logic [31:0] idx, logic [1:0] wlog);
    return fixed ? base : base + (idx << wlog);
  endfunction

  function automatic logic xfer_ok(logic [31:0] len, side_cfg_t s, side_cfg_t d);
    logic [1:0]  wmax;
    logic [31:0] mask;
    wmax = (s.width > d.width) ? s.width : d.width;
    mask = (32'd1 << wmax) - 32'd1;
    return (len != 32'd0) && (s.width != 2'd3) && (d.width != 2'd3) && ((len & mask) == 32'd0);
  endfunction
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fail,
  output logic              go,
  output logic              reject,
  output logic              done_q,
  output logic              err_q,
  output logic [ADDR_W-1:0] src_addr_q,
  output logic [ADDR_W-1:0] dst_addr_q,
  output side_cfg_t         src_cfg_q,
  output side_cfg_t         dst_cfg_q,
  output logic [LEN_W-1:0]  len_q
);
  localparam logic [5:0] OFF_SRC = 6'h00, OFF_SCFG = 6'h04, OFF_DST = 6'h08, OFF_DCFG = 6'h0C;
  localparam logic [5:0] OFF_LEN = 6'h14, OFF_CMD = 6'h18, OFF_STAT = 6'h1C, OFF_DIR = 6'h20;

  logic dir_q;
  logic cmd_wr, start_req, clr_err, clr_done, cfg_good;

  assign cmd_wr    = reg_wr && (reg_addr == OFF_CMD);
  assign start_req = cmd_wr && reg_wdata[0] && !busy;
  assign clr_err   = cmd_wr && reg_wdata[16];
  assign clr_done  = cmd_wr && reg_wdata[18];
  assign cfg_good  = xfer_ok(32'(len_q), src_cfg_q, dst_cfg_q);
  assign go        = start_req && cfg_good;
  assign reject    = start_req && !cfg_good;

  function automatic side_cfg_t unpack_cfg(logic [31:0] w);
    side_cfg_t c;
    c.burst = w[18:16];
    c.fixed = w[8];
    c.width = w[1:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(side_cfg_t c);
    return {13'd0, c.burst, 7'd0, c.fixed, 6'd0, c.width};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_cfg_q  <= '0;
      dst_cfg_q  <= '0;
      len_q      <= '0;
      dir_q      <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_SRC:  src_addr_q <= reg_wdata;
        OFF_SCFG: src_cfg_q  <= unpack_cfg(reg_wdata);
        OFF_DST:  dst_addr_q <= reg_wdata;
        OFF_DCFG: dst_cfg_q  <= unpack_cfg(reg_wdata);
        OFF_LEN:  len_q      <= reg_wdata[LEN_W-1:0];
        OFF_DIR:  dir_q      <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (go) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (clr_err)  err_q  <= 1'b0;
      if (clr_done) done_q <= 1'b0;
      if (fin)      done_q <= 1'b1;
      if (fail || reject) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_SRC:  reg_rdata = src_addr_q;
      OFF_SCFG: reg_rdata = pack_cfg(src_cfg_q);
      OFF_DST:  reg_rdata = dst_addr_q;
      OFF_DCFG: reg_rdata = pack_cfg(dst_cfg_q);
      OFF_LEN:  reg_rdata = 32'(len_q);
      OFF_STAT: reg_rdata = {13'd0, done_q, busy, err_q, 16'd0};
      OFF_DIR:  reg_rdata = {31'd0, dir_q};
      default:  reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int MAX_BURST_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  side_cfg_t         src_cfg,
  input  side_cfg_t         dst_cfg,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              fin,
  output logic              fail,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_strb,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err
);
  localparam int BUF_LOG   = MAX_BURST_LOG + 2;
  localparam int BUF_BYTES = 1 << BUF_LOG;
  localparam int CW        = BUF_LOG + 1;

  dma_state_e        state;
  side_cfg_t         scfg, dcfg;
  logic [ADDR_W-1:0] src_cur, dst_cur;
  logic [LEN_W-1:0]  rem, chunk, limit;
  logic [CW-1:0]     iss_cnt, rsp_cnt, nbeats;
  logic [7:0]        buf_q [BUF_BYTES];
  logic [1:0]        cur_wlog;
  logic [ADDR_W-1:0] rsp_addr;
  logic              last_rsp, capture;
  logic [3:0]        cap_en;
  logic [BUF_LOG-1:0] cap_idx [BUS_BYTES];
  int unsigned       span;

  always_comb begin
    span  = side_span(scfg, MAX_BURST_LOG);
    if (side_span(dcfg, MAX_BURST_LOG) > span) span = side_span(dcfg, MAX_BURST_LOG);
    limit = LEN_W'(1) << span;
    chunk = (rem < limit) ? rem : limit;
  end

  assign busy     = (state != ST_IDLE);
  assign cur_wlog = (state == ST_WR) ? dcfg.width : scfg.width;
  assign nbeats   = CW'(chunk >> cur_wlog);
  assign last_rsp = (rsp_cnt == nbeats - CW'(1));

  assign mem_req_valid = busy && (iss_cnt < nbeats);
  assign mem_req_write = (state == ST_WR);
  assign mem_req_addr  = (state == ST_WR) ? beat_addr(dst_cur, dcfg.fixed, 32'(iss_cnt), dcfg.width)
                                          : beat_addr(src_cur, scfg.fixed, 32'(iss_cnt), scfg.width);

  // Lane placement for the outgoing write beat
  always_comb begin
    mem_req_wdata = '0;
    mem_req_strb  = '0;
    for (int l = 0; l < BUS_BYTES; l++) begin
      if ((l >= int'(mem_req_addr[1:0])) && (l < int'(mem_req_addr[1:0]) + (1 << dcfg.width))) begin
        mem_req_strb[l]        = mem_req_write;
        mem_req_wdata[8*l +: 8] = buf_q[BUF_LOG'((int'(iss_cnt) << dcfg.width) + l - int'(mem_req_addr[1:0]))];
      end
    end
  end

  // Lane extraction for the incoming read response
  assign rsp_addr = beat_addr(src_cur, scfg.fixed, 32'(rsp_cnt), scfg.width);
  assign capture  = (state == ST_RD) && mem_rsp_valid && !mem_rsp_err;

  always_comb begin
    for (int l = 0; l < BUS_BYTES; l++) begin
      cap_en[l]  = capture && (l >= int'(rsp_addr[1:0])) &&
                   (l < int'(rsp_addr[1:0]) + (1 << scfg.width));
      cap_idx[l] = BUF_LOG'((int'(rsp_cnt) << scfg.width) + l - int'(rsp_addr[1:0]));
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < BUS_BYTES; l++) begin
      if (cap_en[l]) buf_q[cap_idx[l]] <= mem_rsp_rdata[8*l +: 8];
    end
  end

  assign fail = busy && mem_rsp_valid && mem_rsp_err;
  assign fin  = (state == ST_WR) && mem_rsp_valid && !mem_rsp_err && last_rsp && (rem == chunk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      scfg    <= '0;
      dcfg    <= '0;
      src_cur <= '0;
      dst_cur <= '0;
      rem     <= '0;
      iss_cnt <= '0;
      rsp_cnt <= '0;
    end else if (state == ST_IDLE) begin
      if (go) begin
        state   <= ST_RD;
        scfg    <= src_cfg;
        dcfg    <= dst_cfg;
        src_cur <= src_base;
        dst_cur <= dst_base;
        rem     <= len;
        iss_cnt <= '0;
        rsp_cnt <= '0;
      end
    end else begin
      if (mem_req_valid && mem_req_ready) iss_cnt <= iss_cnt + CW'(1);
      if (fail) begin
        state <= ST_IDLE;
      end else if (mem_rsp_valid) begin
        rsp_cnt <= rsp_cnt + CW'(1);
        if (last_rsp) begin
          iss_cnt <= '0;
          rsp_cnt <= '0;
          if (state == ST_RD) begin
            state <= ST_WR;
          end else begin
            rem   <= rem - chunk;
            if (!scfg.fixed) src_cur <= src_cur + ADDR_W'(chunk);
            if (!dcfg.fixed) dst_cur <= dst_cur + ADDR_W'(chunk);
            state <= (rem == chunk) ? ST_IDLE : ST_RD;
          end
        end
      end
    end
  end
endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int MAX_BURST_LOG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  output logic [3:0]  mem_req_strb,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        mem_rsp_err
);
  // Named internal events, visible to the bound checker
  logic              eng_busy, ev_fin, ev_fail, ev_go, ev_reject, done_flag, err_flag;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  side_cfg_t         src_cfg, dst_cfg;
  logic [LEN_W-1:0]  len;

  blkdma_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(eng_busy), .fin(ev_fin), .fail(ev_fail),
    .go(ev_go), .reject(ev_reject), .done_q(done_flag), .err_q(err_flag),
    .src_addr_q(src_addr), .dst_addr_q(dst_addr),
    .src_cfg_q(src_cfg), .dst_cfg_q(dst_cfg), .len_q(len)
  );

  blkdma_engine #(.LEN_W(LEN_W), .MAX_BURST_LOG(MAX_BURST_LOG)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(ev_go),
    .src_base(src_addr), .dst_base(dst_addr),
    .src_cfg(src_cfg), .dst_cfg(dst_cfg), .len(len),
    .busy(eng_busy), .fin(ev_fin), .fail(ev_fail),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err)
  );
endmodule

// File: rtl/blkdma_checker.sv
module blkdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done_flag,
  input logic        err_flag,
  input logic        ev_fin,
  input logic        ev_fail,
  input logic        ev_reject,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic [3:0]  req_strb,
  input logic        rsp_valid,
  input logic        rsp_err
);
  assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_busy_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_flag);

  assert_fin_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fin |=> (done_flag && !busy));

  assert_reject_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (done_flag && err_flag && !busy));

  assert_fail_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (done_flag && err_flag && !busy && !req_valid));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !(rsp_valid && rsp_err)) |=>
      (req_valid && $stable(req_addr) && $stable(req_write)));

  assert_wdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_ready && !(rsp_valid && rsp_err)) |=>
      ($stable(req_wdata) && $stable(req_strb)));

  assert_strb_shape_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |->
      ($countones(req_strb) == 1 || $countones(req_strb) == 2 || $countones(req_strb) == 4));
endmodule

bind blkdma_top blkdma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done_flag(done_flag), .err_flag(err_flag),
  .ev_fin(ev_fin), .ev_fail(ev_fail), .ev_reject(ev_reject),
  .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
  .req_addr(mem_req_addr), .req_wdata(mem_req_wdata), .req_strb(mem_req_strb),
  .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err)
);

// File: tb/blkdma_top_test.sv
module blkdma_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ST_DONE = 32'h0004_0000, ST_BUSY = 32'h0002_0000, ST_ERR = 32'h0001_0000;

  typedef struct packed {
    logic [7:0]  src;
    logic [31:0] scfg;
    logic [7:0]  dst;
    logic [31:0] dcfg;
    logic [15:0] size;
    logic [7:0]  first;
  } vec_t;

  // config word: burst in 18:16, fixed in 8, width in 1:0
  localparam vec_t VECS [6] = '{
    '{8'h00, 32'h0004_0001, 8'h80, 32'h0004_0002, 16'd100, 8'd32},
    '{8'h10, 32'h0002_0002, 8'h90, 32'h0003_0001, 16'd24,  8'd4},
    '{8'h20, 32'h0000_0000, 8'hA0, 32'h0000_0002, 16'd8,   8'd4},
    '{8'h30, 32'h0000_0101, 8'hB0, 32'h0002_0002, 16'd16,  8'd8},
    '{8'h40, 32'h0003_0001, 8'hC0, 32'h0000_0102, 16'd12,  8'd6},
    '{8'h52, 32'h0001_0001, 8'hD2, 32'h0002_0001, 16'd6,   8'd3}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_write, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic [3:0]  mem_req_strb;
  logic        mem_req_ready;

  logic [7:0]  mem [256];
  logic [7:0]  expm [256];
  logic        init_req = 1'b0, stall_en = 1'b0, poison_en = 1'b0;
  logic [7:0]  poison_addr = '0;
  int          cyc = 0, rd_cnt = 0, wr_cnt = 0, rd_first = 0;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkdma_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_strb(mem_req_strb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  assign mem_req_ready = !stall_en || ((cyc % 3) != 1);

  // Memory model: one response per accepted request, next cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      rd_cnt <= 0; wr_cnt <= 0; rd_first <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= poison_en && (mem_req_addr[7:0] == poison_addr);
      if (mem_req_write) begin
        wr_cnt <= wr_cnt + 1;
        for (int l = 0; l < 4; l++)
          if (mem_req_strb[l]) mem[{mem_req_addr[7:2], 2'(l)}] <= mem_req_wdata[8*l +: 8];
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (wr_cnt == 0) rd_first <= rd_first + 1;
        mem_rsp_rdata <= {mem[{mem_req_addr[7:2], 2'd3}], mem[{mem_req_addr[7:2], 2'd2}],
                          mem[{mem_req_addr[7:2], 2'd1}], mem[{mem_req_addr[7:2], 2'd0}]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_reset();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic setup(input vec_t v);
    wr_reg(6'h00, 32'(v.src));
    wr_reg(6'h04, v.scfg);
    wr_reg(6'h08, 32'(v.dst));
    wr_reg(6'h0C, v.dcfg);
    wr_reg(6'h14, 32'(v.size));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin rd_reg(6'h1C, s); n++; end while (s[17] && n < 5000);
    repeat (4) @(negedge clk);
  endtask

  // Expected destination image, computed byte by byte in source order
  task automatic build_exp(input vec_t v);
    int sw, dw, sa, da;
    sw = 1 << v.scfg[1:0];
    dw = 1 << v.dcfg[1:0];
    for (int i = 0; i < 256; i++) expm[i] = pat(i);
    for (int i = 0; i < int'(v.size); i++) begin
      sa = v.scfg[8] ? int'(v.src) + (i % sw) : int'(v.src) + i;
      da = v.dcfg[8] ? int'(v.dst) + (i % dw) : int'(v.dst) + i;
      expm[da] = pat(sa);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  logic [31:0] s;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: idle, nothing set (R3, R4)
    rd_reg(6'h1C, s);  chk("R3 reset status", s, 32'd0);

    // R1 register readback
    wr_reg(6'h00, 32'h1234_5678); rd_reg(6'h00, s); chk("R1 src addr", s, 32'h1234_5678);
    wr_reg(6'h04, 32'hFFFF_FFFF); rd_reg(6'h04, s); chk("R1 R2 cfg fields", s, 32'h0007_0103);
    wr_reg(6'h20, 32'h0000_0003); rd_reg(6'h20, s); chk("R1 dir", s, 32'd1);
    wr_reg(6'h14, 32'hABCD_0064); rd_reg(6'h14, s); chk("R1 size", s, 32'h0000_0064);
    rd_reg(6'h18, s); chk("R1 cmd reads 0", s, 32'd0);

    // Table walk: R2 R7 R8 R9
    for (int k = 0; k < 6; k++) begin
      stall_en = (k % 2) == 1;
      mem_reset();
      setup(VECS[k]);
      build_exp(VECS[k]);
      wr_reg(6'h18, 32'h0000_0001);
      wait_idle();
      cmp_mem($sformatf("R7 R9 vector %0d data", k));
      chk($sformatf("R8 vector %0d reads", k), 32'(rd_cnt), 32'(int'(VECS[k].size) >> VECS[k].scfg[1:0]));
      chk($sformatf("R8 vector %0d reads before first write", k), 32'(rd_first), 32'(VECS[k].first));
      rd_reg(6'h1C, s); chk($sformatf("R4 vector %0d status", k), s, ST_DONE);
    end

    // R4 done stays set, R3 valid start clears it and shows busy
    repeat (20) @(negedge clk);
    rd_reg(6'h1C, s); chk("R4 done sticky", s, ST_DONE);
    stall_en = 1'b1;
    mem_reset();
    setup(VECS[0]);
    wr_reg(6'h18, 32'h0000_0001);
    rd_reg(6'h1C, s); chk("R3 busy after start", s, ST_BUSY);
    // R11 second start while busy is ignored
    repeat (10) @(negedge clk);
    wr_reg(6'h18, 32'h0000_0001);
    wait_idle();
    build_exp(VECS[0]);
    cmp_mem("R11 data unchanged");
    chk("R11 read count", 32'(rd_cnt), 32'd50);
    rd_reg(6'h1C, s); chk("R11 status", s, ST_DONE);
    wr_reg(6'h18, 32'h0004_0000);
    rd_reg(6'h1C, s); chk("R4 done cleared", s, 32'd0);
    stall_en = 1'b0;

    // R6 invalid starts
    mem_reset();
    wr_reg(6'h04, 32'h0000_0001); wr_reg(6'h0C, 32'h0000_0002); wr_reg(6'h14, 32'd0);
    wr_reg(6'h18, 32'h0000_0001); repeat (3) @(negedge clk);
    rd_reg(6'h1C, s); chk("R6 zero size", s, ST_DONE | ST_ERR);
    chk("R6 zero size no requests", 32'(rd_cnt + wr_cnt), 32'd0);
    wr_reg(6'h18, 32'h0005_0000);
    wr_reg(6'h14, 32'd6); wr_reg(6'h18, 32'h0000_0001); repeat (3) @(negedge clk);
    rd_reg(6'h1C, s); chk("R6 size not multiple", s, ST_DONE | ST_ERR);
    wr_reg(6'h18, 32'h0005_0000);
    wr_reg(6'h14, 32'd8); wr_reg(6'h04, 32'h0000_0003); wr_reg(6'h18, 32'h0000_0001); repeat (3) @(negedge clk);
    rd_reg(6'h1C, s); chk("R6 width code 3", s, ST_DONE | ST_ERR);
    chk("R6 no requests", 32'(rd_cnt + wr_cnt), 32'd0);
    wr_reg(6'h18, 32'h0005_0000);

    // R10 memory error response, then R5 clear order
    mem_reset();
    setup(VECS[2]);
    poison_addr = 8'h22; poison_en = 1'b1;
    wr_reg(6'h18, 32'h0000_0001);
    wait_idle();
    poison_en = 1'b0;
    rd_reg(6'h1C, s); chk("R10 error status", s, ST_DONE | ST_ERR);
    chk("R10 no writes", 32'(wr_cnt), 32'd0);
    wr_reg(6'h18, 32'h0001_0000);
    rd_reg(6'h1C, s); chk("R5 error cleared, done kept", s, ST_DONE);
    wr_reg(6'h18, 32'h0004_0000);
    rd_reg(6'h1C, s); chk("R5 done cleared", s, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule